// File: doc/BRIEF.md
# Colored-Button Sequence Lock

This block is a Moore state machine that opens a lock only after a start press followed by a fixed order of color presses: red, then blue, then green, then red again. Three color buttons and a start button feed it, together with an "any color" line that the surrounding logic forms as the OR of the three color lines. Each color press is expected as a one-cycle pulse from an external one-shot stage.

While the machine is armed and no color is pressed it simply waits. A press counts as progress only when exactly one color line is high and it is the color expected at that step. A wrong color, a press of several colors at once, or an "any color" pulse with no single matching color sends the machine back to its idle state. This closes the bypass where holding every button at once would walk through the whole sequence. When the final red is accepted the unlock output goes high for exactly one cycle, and the machine then returns to idle by itself.

The code length and the code itself are parameters. Colors are numbered red = 0, green = 1, blue = 2. A parameter also selects binary or one-hot storage for the progress state.

Top module: `seq_lock`

## Requirements
- R1: `rst` is synchronous and active-high. An edge with `rst` = 1 places the lock in idle with `unlock` = 0, and any sequence progress made before the reset is lost.
- R2: In idle, the lock arms at an edge where `start_btn` = 1. Otherwise it stays idle whatever the color lines carry.
- R3: When the lock is armed or partway through the code and `any_btn` = 0, it holds its position, even if a color line is high.
- R4: With `any_btn` = 1, a press advances one step only when exactly one color line is high and it matches the expected color. The default order is red, blue, green, red (color indices 0, 2, 1, 0, with step 0 in the lowest two bits of the code parameter).
- R5: When the lock is armed or partway through the code and `any_btn` = 1, a single wrong color, or no color line at all, returns it to idle.
- R6: A press with two or more color lines high returns the lock to idle. Holding every button at once therefore never unlocks.
- R7: `unlock` is 1 in the cycle after the edge that accepts the last code color, and only then. It lasts exactly one cycle, after which the lock is idle whatever the inputs are.
- R8: `start_btn` has no effect once the lock is armed or partway through the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Start button level |
| red_btn | input | 1 | Red button pulse (color index 0) |
| green_btn | input | 1 | Green button pulse (color index 1) |
| blue_btn | input | 1 | Blue button pulse (color index 2) |
| any_btn | input | 1 | OR of the three color lines |
| unlock | output | 1 | One-cycle unlock level |

## Verification
The bound checker watches several properties on every cycle:
- reset forces idle;
- idle holds without a start press;
- the lock holds with no color press, and a start press after arming is ignored;
- a multi-color press always clears progress;
- unlock never lasts two cycles and only rises from the last code step.

Whether each single press moves the lock to the right step can only be seen from the bench's scenarios. The bench steers the lock into every state and applies every combination of the five inputs there. It then drives the correct remainder of the code and compares when `unlock` fires against its own model of the transitions.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

   localparam int COLOR_CNT = 3;
   localparam int IDX_W     = 2;

   localparam int IDX_RED   = 0;
   localparam int IDX_GREEN = 1;
   localparam int IDX_BLUE  = 2;

   typedef enum logic [1:0] {
      EV_IDLE  = 2'd0,
      EV_MATCH = 2'd1,
      EV_MISS  = 2'd2
   } press_ev_e;

   function automatic int pos_width(input int steps);
      return $clog2(steps + 2);
   endfunction

endpackage

// File: rtl/seq_lock_press_eval.sv
module seq_lock_press_eval
   import seq_lock_pkg::*;
#(
   parameter int N_COLORS = COLOR_CNT,
   parameter int SEL_W    = IDX_W
) (
   input  logic [N_COLORS-1:0] colors,
   input  logic                any_press,
   input  logic [SEL_W-1:0]    want_idx,
   output press_ev_e           ev
);

   logic [N_COLORS-1:0] want_vec;

   always_comb begin
      for (int i = 0; i < N_COLORS; i++) begin
         want_vec[i] = (want_idx == SEL_W'(i));
      end
   end

   always_comb begin
      if (!any_press) begin
         ev = EV_IDLE;
      end else if (colors == want_vec) begin
         ev = EV_MATCH;
      end else begin
         ev = EV_MISS;
      end
   end

endmodule

// File: rtl/seq_lock_code_rom.sv
module seq_lock_code_rom
   import seq_lock_pkg::*;
#(
   parameter int                      CODE_LEN = 4,
   parameter int                      SEL_W    = IDX_W,
   parameter int                      POS_W    = pos_width(CODE_LEN),
   parameter logic [CODE_LEN*SEL_W-1:0] CODE   = '0
) (
   input  logic [POS_W-1:0] pos,
   output logic [SEL_W-1:0] want_idx
);

   always_comb begin
      want_idx = '0;
      for (int k = 0; k < CODE_LEN; k++) begin
         if (pos == POS_W'(k + 1)) begin
            want_idx = CODE[k*SEL_W +: SEL_W];
         end
      end
   end

endmodule

// File: rtl/seq_lock_tracker.sv
module seq_lock_tracker
   import seq_lock_pkg::*;
#(
   parameter int CODE_LEN  = 4,
   parameter int POS_W     = pos_width(CODE_LEN),
   parameter bit ONE_HOT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  press_ev_e        ev,
   output logic [POS_W-1:0] pos
);

   localparam int               N_STATES = CODE_LEN + 2;
   localparam logic [POS_W-1:0] OPEN_POS = POS_W'(CODE_LEN + 1);

   logic [POS_W-1:0] nxt;

   always_comb begin
      if (pos == '0) begin
         nxt = start ? POS_W'(1) : '0;
      end else if (pos == OPEN_POS) begin
         nxt = '0;
      end else begin
         case (ev)
            EV_MATCH: nxt = pos + POS_W'(1);
            EV_MISS:  nxt = '0;
            default:  nxt = pos;
         endcase
      end
   end

   generate
      if (ONE_HOT) begin : g_hot
         logic [N_STATES-1:0] hot_q;
         logic [N_STATES-1:0] hot_d;

         always_comb begin
            for (int i = 0; i < N_STATES; i++) begin
               hot_d[i] = (nxt == POS_W'(i));
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               hot_q <= N_STATES'(1);
            end else begin
               hot_q <= hot_d;
            end
         end

         always_comb begin
            pos = '0;
            for (int i = 0; i < N_STATES; i++) begin
               if (hot_q[i]) begin
                  pos = pos | POS_W'(i);
               end
            end
         end
      end else begin : g_bin
         logic [POS_W-1:0] pos_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               pos_q <= '0;
            end else begin
               pos_q <= nxt;
            end
         end

         assign pos = pos_q;
      end
   endgenerate

endmodule

// File: rtl/seq_lock.sv
module seq_lock
   import seq_lock_pkg::*;
#(
   parameter int                      CODE_LEN      = 4,
   parameter logic [CODE_LEN*IDX_W-1:0] CODE        = 8'b00_01_10_00,
   parameter bit                      ONE_HOT_STATE = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic start_btn,
   input  logic red_btn,
   input  logic green_btn,
   input  logic blue_btn,
   input  logic any_btn,
   output logic unlock
);

   localparam int               POS_W    = pos_width(CODE_LEN);
   localparam logic [POS_W-1:0] OPEN_POS = POS_W'(CODE_LEN + 1);

   generate
      if (CODE_LEN < 1) begin : g_len_bad
         $error("seq_lock: CODE_LEN must be at least 1");
      end
      for (genvar k = 0; k < CODE_LEN; k++) begin : g_code_chk
         if (CODE[k*IDX_W +: IDX_W] >= COLOR_CNT) begin : g_bad
            $error("seq_lock: code entry names a color that does not exist");
         end
      end
   endgenerate

   logic [COLOR_CNT-1:0] colors;
   logic [IDX_W-1:0]     want_idx;
   logic [POS_W-1:0]     pos;
   press_ev_e            ev;

   always_comb begin
      colors            = '0;
      colors[IDX_RED]   = red_btn;
      colors[IDX_GREEN] = green_btn;
      colors[IDX_BLUE]  = blue_btn;
   end

   seq_lock_code_rom #(
      .CODE_LEN (CODE_LEN),
      .SEL_W    (IDX_W),
      .POS_W    (POS_W),
      .CODE     (CODE)
   ) u_rom (
      .pos      (pos),
      .want_idx (want_idx)
   );

   seq_lock_press_eval #(
      .N_COLORS (COLOR_CNT),
      .SEL_W    (IDX_W)
   ) u_eval (
      .colors    (colors),
      .any_press (any_btn),
      .want_idx  (want_idx),
      .ev        (ev)
   );

   seq_lock_tracker #(
      .CODE_LEN (CODE_LEN),
      .POS_W    (POS_W),
      .ONE_HOT  (ONE_HOT_STATE)
   ) u_track (
      .clk   (clk),
      .rst   (rst),
      .start (start_btn),
      .ev    (ev),
      .pos   (pos)
   );

   assign unlock = (pos == OPEN_POS);

endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk #(
   parameter int               POS_W    = 3,
   parameter logic [POS_W-1:0] OPEN_POS = 3'd5
) (
   input logic             clk,
   input logic             rst,
   input logic             start_btn,
   input logic             red_btn,
   input logic             green_btn,
   input logic             blue_btn,
   input logic             any_btn,
   input logic             unlock,
   input logic [POS_W-1:0] pos
);

   logic mid;
   assign mid = (pos != '0) && (pos != OPEN_POS);

   AST_RESET_TO_WAIT: assert property (@(posedge clk)
      rst |=> (pos == '0 && !unlock)); // R1

   AST_WAIT_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
      (pos == '0 && !start_btn) |=> (pos == '0)); // R2

   AST_HOLD_NO_PRESS: assert property (@(posedge clk) disable iff (rst)
      (mid && !any_btn) |=> $stable(pos)); // R3

   AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      (pos <= OPEN_POS)); // R4

   AST_MULTI_PRESS_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (mid && any_btn && $countones({red_btn, green_btn, blue_btn}) > 1) |=> (pos == '0)); // R6

   AST_UNLOCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      unlock |=> !unlock); // R7

   AST_UNLOCK_FROM_LAST: assert property (@(posedge clk) disable iff (rst)
      $rose(unlock) |-> ($past(pos) == OPEN_POS - 1'b1)); // R7

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (mid && start_btn && !any_btn) |=> $stable(pos)); // R8

endmodule

bind seq_lock seq_lock_chk #(
   .POS_W    (POS_W),
   .OPEN_POS (OPEN_POS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start_btn (start_btn),
   .red_btn   (red_btn),
   .green_btn (green_btn),
   .blue_btn  (blue_btn),
   .any_btn   (any_btn),
   .unlock    (unlock),
   .pos       (pos)
);

// File: tb/seq_lock_bench.sv
`timescale 1ns/1ps
module seq_lock_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_btn = 1'b0;
   logic red_btn = 1'b0;
   logic green_btn = 1'b0;
   logic blue_btn = 1'b0;
   logic any_btn = 1'b0;
   logic unlock;

   int checks = 0;
   int fails  = 0;
   int mp     = 0;
   bit done   = 1'b0;

   // R4: color order red(0), blue(2), green(1), red(0)
   int seq_idx [4] = '{0, 2, 1, 0};

   always #5 clk = ~clk;

   seq_lock u_seq_lock (
      .clk       (clk),
      .rst       (rst),
      .start_btn (start_btn),
      .red_btn   (red_btn),
      .green_btn (green_btn),
      .blue_btn  (blue_btn),
      .any_btn   (any_btn),
      .unlock    (unlock)
   );

   function automatic int model_next(int p, bit s, bit r, bit g, bit b, bit a);
      int want;
      bit [2:0] cv;
      bit [2:0] wv;
      if (p == 0) return s ? 1 : 0;
      if (p == 5) return 0;
      if (!a) return p;
      want = seq_idx[p-1];
      cv = {b, g, r};
      wv = 3'b001 << want;
      if (cv == wv) return p + 1;
      return 0;
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s unlock=%0b expected=%0b (model state %0d)", tag, act, exp, mp);
      end
   endtask

   task automatic cycle(input bit s, input bit r, input bit g, input bit b, input bit a,
                        input string tag);
      @(negedge clk);
      check(unlock, (mp == 5), tag);
      start_btn = s;
      red_btn   = r;
      green_btn = g;
      blue_btn  = b;
      any_btn   = a;
      mp = model_next(mp, s, r, g, b, a);
   endtask

   task automatic probe(input string tag);
      if (mp == 0) begin
         cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
      end else if (mp == 5) begin
         cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
      end else begin
         int w = seq_idx[mp-1];
         cycle(1'b0, w == 0, w == 1, w == 2, 1'b1, tag);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      start_btn = 1'b0; red_btn = 1'b0; green_btn = 1'b0;
      blue_btn = 1'b0;  any_btn = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(unlock, 1'b0, "R1");
      rst = 1'b0;
      mp = 0;
   endtask

   function automatic string classify(int st, bit [4:0] cv);
      int cnt;
      int want;
      cnt = int'(cv[3]) + int'(cv[2]) + int'(cv[1]);
      if (st == 0) return "R2";
      if (st == 5) return "R7";
      if (!cv[0]) return cv[4] ? "R8" : "R3";
      if (cnt > 1) return "R6";
      want = seq_idx[st-1];
      if (cnt == 1 && ((want == 0 && cv[3]) || (want == 1 && cv[2]) || (want == 2 && cv[1])))
         return "R4";
      return "R5";
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired before the run ended");
      finish_run();
   end

   initial begin
      do_reset();

      // R7: full correct sequence, one-cycle unlock
      for (int i = 0; i < 8; i++) probe("R7");

      // R1: reset in the middle of the sequence discards progress
      do_reset();
      for (int i = 0; i < 4; i++) probe("R1");
      do_reset();
      cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
      cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
      cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

      // R6: all buttons held through every step never unlocks
      do_reset();
      cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
      for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");

      // Sweep: every state, every combination of the five inputs
      for (int st = 0; st < 6; st++) begin
         for (int c = 0; c < 32; c++) begin
            bit [4:0] cv = 5'(c);
            string tag;
            do_reset();
            for (int i = 0; i < st; i++) probe("R4");
            tag = classify(st, cv);
            cycle(cv[4], cv[3], cv[2], cv[1], cv[0], tag);
            for (int i = 0; i < 7; i++) probe(tag);
         end
      end

      @(negedge clk);
      check(unlock, (mp == 5), "R7");
      finish_run();
   end

endmodule